// File: doc/BRIEF.md
# SPI Tunnel Capture Framer

This block sits at the far end of a serial link and watches a local SPI bus that an external master drives. Slave select, SPI clock and MOSI are asynchronous to the block. They pass through synchronizers into the block's free-running clock. A MOSI bit is captured each time the synchronized SPI clock shows its sampling edge while slave select is low. Captured bits wait in a small FIFO.

A frame timer expires once every `frame_period` cycles. When it expires, the block raises a frame toward the link transmitter and holds it until the transmitter accepts it with valid/ready. Each frame has three fields:
- a slave-select flag;
- a bit count;
- a 4-bit data field, filled from the MSB in the order the bits were captured.

In write mode a frame carries up to four bits. In read mode it carries at most one, so a master that waits for a round-trip response gets one sample per frame.

The slave-select flag reports high if slave select was high at any time since the previous frame. A brief deassertion therefore always reaches the far side. If the FIFO overflows, a sticky error flag is set.

Top module: `spi_tunnel_framer`

## Requirements
- R1: After synchronous reset, `frm_valid` is 0 and `ovf_err` is 0.
- R2: With `frm_ready` held at 1, frames are accepted exactly once every `frame_period` clock cycles.
- R3: Once `frm_valid` is 1, it stays 1 until a cycle in which `frm_ready` is 1.
- R4: A MOSI bit is captured only on a sampling edge of the synchronized SPI clock while slave select is low. Edges seen while slave select is high add no bits to any frame.
- R5: Bits leave in capture order, none lost or repeated. The earliest bit of a frame sits in `frm_data[3]`. Data bit positions at or beyond `frm_count` are 0.
- R6: In write mode (`read_mode` = 0), `frm_count` never exceeds 4.
- R7: In read mode (`read_mode` = 1), `frm_count` never exceeds 1.
- R8: `frm_ss` is 1 in a frame if the synchronized slave select was high at any cycle since the previous accepted frame; otherwise it is 0.
- R9: The FIFO holds 8 bits. A bit captured while it is full is dropped and sets `ovf_err`, which stays 1 until reset.
- R10: A frame is sent at every period even with no data. It then carries `frm_count` = 0 and the current slave-select flag.
- R11: `spi_mode` values 0 and 3 sample on the rising SPI clock edge; values 1 and 2 sample on the falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local free-running clock |
| rst | input | 1 | Synchronous active-high reset |
| ss_n_in | input | 1 | Asynchronous slave select, active low |
| sclk_in | input | 1 | Asynchronous SPI clock |
| mosi_in | input | 1 | Asynchronous SPI data from the master |
| spi_mode | input | 2 | Clock mode selecting the sampling edge |
| read_mode | input | 1 | Strap: 1 limits each frame to one bit |
| frame_period | input | 16 | Frame spacing in clock cycles |
| frm_valid | output | 1 | Frame available |
| frm_ready | input | 1 | Transmitter accepts the frame |
| frm_ss | output | 1 | Slave-select flag of the frame |
| frm_count | output | 3 | Number of data bits in the frame |
| frm_data | output | 4 | Data bits, earliest in bit 3 |
| ovf_err | output | 1 | Sticky FIFO overflow flag |

## Verification
A SPI clock edge at the pins reaches the FIFO four cycles later: two synchronizer stages, the edge register, and the FIFO write. The bench therefore keeps MOSI stable for several cycles around each sampling edge, and waits at least eight cycles after the last edge before raising slave select.

The scoreboard compares bits in order at each accepted frame, not at fixed cycles. This lets a bit fall into either of two neighbouring frames without a false failure.

Frame spacing is checked as an exact cycle count between accepted frames, but only while ready stays high. A slave-select pulse is expected in the first frame after it and must be gone from the frame after that.

// File: rtl/spi_tun_pkg.sv
package spi_tun_pkg;

    localparam int DATA_W = 4;
    localparam int CNT_W  = $clog2(DATA_W + 1);

    typedef struct packed {
        logic              ss;
        logic [CNT_W-1:0]  count;
        logic [DATA_W-1:0] data;
    } frame_t;

    // CPOL xor CPHA == 0 samples on the rising edge
    function automatic logic samples_on_rise(input logic [1:0] mode);
        return (mode[1] ^ mode[0]) == 1'b0;
    endfunction

endpackage

// File: rtl/spi_tun_sync.sv
module spi_tun_sync #(
    parameter int               WIDTH   = 3,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stage_q[g] <= RST_VAL;
                else     stage_q[g] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stage_q[g] <= RST_VAL;
                else     stage_q[g] <= stage_q[g-1];
            end
        end
    end

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/spi_tun_capture.sv
module spi_tun_capture
    import spi_tun_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ss_n_s,
    input  logic       sclk_s,
    input  logic       mosi_s,
    input  logic [1:0] spi_mode,
    output logic       push,
    output logic       push_bit
);

    logic sclk_q;
    logic rise, fall, hit;

    assign rise = sclk_s & ~sclk_q;
    assign fall = ~sclk_s & sclk_q;
    assign hit  = samples_on_rise(spi_mode) ? rise : fall;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q   <= 1'b0;
            push     <= 1'b0;
            push_bit <= 1'b0;
        end else begin
            sclk_q   <= sclk_s;
            push     <= hit & ~ss_n_s;
            push_bit <= mosi_s;
        end
    end

    AST_NO_CAPTURE_SS_HIGH: assert property (@(posedge clk) disable iff (rst)
        push |-> $past(!ss_n_s)); // R4

endmodule

// File: rtl/spi_tun_fifo.sv
module spi_tun_fifo #(
    parameter  int DEPTH   = 8,
    parameter  int MAX_POP = 4,
    localparam int PTR_W   = $clog2(DEPTH),
    localparam int POP_W   = $clog2(MAX_POP + 1),
    localparam int FILL_W  = PTR_W + 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               push,
    input  logic               push_bit,
    input  logic [POP_W-1:0]   pop_n,
    output logic [FILL_W-1:0]  fill,
    output logic [MAX_POP-1:0] peek,
    output logic               overflow
);

    logic [DEPTH-1:0] mem;
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             push_ok;

    assign overflow = push && (fill == FILL_W'(DEPTH));
    assign push_ok  = push && !overflow;

    always_ff @(posedge clk) begin
        if (rst) begin
            mem    <= '0;
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (push_ok) begin
                mem[wr_ptr] <= push_bit;
                wr_ptr      <= wr_ptr + PTR_W'(1);
            end
            rd_ptr <= rd_ptr + PTR_W'(pop_n);
            fill   <= fill + FILL_W'(push_ok) - FILL_W'(pop_n);
        end
    end

    for (genvar g = 0; g < MAX_POP; g++) begin : g_peek
        assign peek[g] = mem[rd_ptr + PTR_W'(g)];
    end

    AST_POP_WITHIN_FILL: assert property (@(posedge clk) disable iff (rst)
        FILL_W'(pop_n) <= fill); // R5

    AST_FILL_BOUND: assert property (@(posedge clk) disable iff (rst)
        fill <= FILL_W'(DEPTH)); // R9

endmodule

// File: rtl/spi_tunnel_framer.sv
module spi_tunnel_framer
    import spi_tun_pkg::*;
#(
    parameter int TMR_W      = 16,
    parameter int FIFO_DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ss_n_in,
    input  logic              sclk_in,
    input  logic              mosi_in,
    input  logic [1:0]        spi_mode,
    input  logic              read_mode,
    input  logic [TMR_W-1:0]  frame_period,
    output logic              frm_valid,
    input  logic              frm_ready,
    output logic              frm_ss,
    output logic [CNT_W-1:0]  frm_count,
    output logic [DATA_W-1:0] frm_data,
    output logic              ovf_err
);

    localparam int FILL_W = $clog2(FIFO_DEPTH) + 1;

    logic [2:0]        sync_q;
    logic              ss_s, sclk_s, mosi_s;
    logic              push, push_bit, overflow;
    logic [FILL_W-1:0] fill;
    logic [DATA_W-1:0] peek;
    logic [CNT_W-1:0]  limit, take, pop_n;
    logic [TMR_W-1:0]  timer;
    logic              expire, pend, hi_seen, accept;
    frame_t            frm;

    spi_tun_sync #(.WIDTH(3), .STAGES(2), .RST_VAL(3'b100)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({ss_n_in, sclk_in, mosi_in}),
        .q   (sync_q)
    );
    assign {ss_s, sclk_s, mosi_s} = sync_q;

    spi_tun_capture u_cap (
        .clk      (clk),
        .rst      (rst),
        .ss_n_s   (ss_s),
        .sclk_s   (sclk_s),
        .mosi_s   (mosi_s),
        .spi_mode (spi_mode),
        .push     (push),
        .push_bit (push_bit)
    );

    spi_tun_fifo #(.DEPTH(FIFO_DEPTH), .MAX_POP(DATA_W)) u_fifo (
        .clk      (clk),
        .rst      (rst),
        .push     (push),
        .push_bit (push_bit),
        .pop_n    (pop_n),
        .fill     (fill),
        .peek     (peek),
        .overflow (overflow)
    );

    // frame assembly
    assign limit  = read_mode ? CNT_W'(1) : CNT_W'(DATA_W);
    assign take   = (int'(fill) > int'(limit)) ? limit : CNT_W'(fill);
    assign accept = pend && frm_ready;
    assign pop_n  = accept ? take : '0;

    always_comb begin
        frm.ss    = ss_s | hi_seen;
        frm.count = take;
        frm.data  = '0;
        for (int i = 0; i < DATA_W; i++) begin
            if (i < int'(take)) frm.data[DATA_W-1-i] = peek[i];
        end
    end

    assign frm_valid = pend;
    assign frm_ss    = frm.ss;
    assign frm_count = frm.count;
    assign frm_data  = frm.data;

    // frame timer and pending flag
    assign expire = ({1'b0, timer} + (TMR_W+1)'(1)) >= {1'b0, frame_period};

    always_ff @(posedge clk) begin
        if (rst) begin
            timer   <= '0;
            pend    <= 1'b0;
            hi_seen <= 1'b1;
            ovf_err <= 1'b0;
        end else begin
            timer <= expire ? '0 : timer + TMR_W'(1);
            if (expire)      pend <= 1'b1;
            else if (accept) pend <= 1'b0;
            if (accept)    hi_seen <= ss_s;
            else if (ss_s) hi_seen <= 1'b1;
            if (overflow) ovf_err <= 1'b1;
        end
    end

    AST_VALID_HOLD: assert property (@(posedge clk) disable iff (rst)
        (frm_valid && !frm_ready) |=> frm_valid); // R3

    AST_WR_COUNT_MAX: assert property (@(posedge clk) disable iff (rst)
        (frm_valid && !read_mode) |-> (int'(frm_count) <= DATA_W)); // R6

    AST_RD_COUNT_MAX: assert property (@(posedge clk) disable iff (rst)
        (frm_valid && read_mode) |-> (int'(frm_count) <= 1)); // R7

    AST_SS_KEPT: assert property (@(posedge clk) disable iff (rst)
        (ss_s && !accept) |=> frm_ss); // R8

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        ovf_err |=> ovf_err); // R9

    AST_EMPTY_PAD: assert property (@(posedge clk) disable iff (rst)
        (frm_valid && frm_count == '0) |-> (frm_data == '0)); // R10

endmodule

// File: tb/spi_tunnel_framer_tb.sv
`timescale 1ns/1ps
module spi_tunnel_framer_tb_top;

    localparam int PERIOD = 40;

    logic        clk = 1'b0;
    logic        rst, ss_n, sclk, mosi, read_mode, frm_ready;
    logic [1:0]  spi_mode;
    logic [15:0] frame_period;
    logic        frm_valid, frm_ss, ovf_err;
    logic [2:0]  frm_count;
    logic [3:0]  frm_data;

    always #10 clk = ~clk;

    spi_tunnel_framer dut_i (
        .clk          (clk),
        .rst          (rst),
        .ss_n_in      (ss_n),
        .sclk_in      (sclk),
        .mosi_in      (mosi),
        .spi_mode     (spi_mode),
        .read_mode    (read_mode),
        .frame_period (frame_period),
        .frm_valid    (frm_valid),
        .frm_ready    (frm_ready),
        .frm_ss       (frm_ss),
        .frm_count    (frm_count),
        .frm_data     (frm_data),
        .ovf_err      (ovf_err)
    );

    bit exp_q[$];
    int n_chk = 0, n_fail = 0, frames = 0, bits_rx = 0, cyc = 0, prev_hs = -1;
    bit chk_interval = 0, done = 0;
    logic last_ss;
    int   last_cnt;

    always @(posedge clk) cyc++;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin : mon
        int lim;
        if (!rst && frm_valid && frm_ready) begin
            frames++;
            last_ss  = frm_ss;
            last_cnt = int'(frm_count);
            lim = read_mode ? 1 : 4;
            chk(int'(frm_count) <= lim, read_mode ? "R7 count limit" : "R6 count limit",
                int'(frm_count), lim);
            for (int i = 0; i < 4; i++) begin
                if (i < int'(frm_count)) begin
                    bits_rx++;
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R5 unexpected bit", int'(frm_data[3-i]), -1);
                    end else begin
                        bit e;
                        e = exp_q.pop_front();
                        chk(frm_data[3-i] == e, "R5 bit order", int'(frm_data[3-i]), int'(e));
                    end
                end else begin
                    chk(frm_data[3-i] == 1'b0, "R5 pad zero", int'(frm_data[3-i]), 0);
                end
            end
            if (chk_interval) begin
                if (prev_hs >= 0) chk(cyc - prev_hs == PERIOD, "R2 spacing", cyc - prev_hs, PERIOD);
                prev_hs = cyc;
            end else begin
                prev_hs = -1;
            end
        end
    end

    task automatic send_bit(input bit b, input int half, input bit keep);
        if (keep) exp_q.push_back(b);
        if (spi_mode == 2'd0 || spi_mode == 2'd3) begin
            mosi = b; tick(half); sclk = 1'b1; tick(half); sclk = 1'b0;
        end else begin
            sclk = 1'b1; mosi = b; tick(half); sclk = 1'b0; tick(half);
        end
    endtask

    task automatic wait_frames(input int n);
        int k;
        k = frames;
        while (frames < k + n) tick(1);
    endtask

    task automatic wait_drain();
        while (exp_q.size() != 0) tick(1);
        wait_frames(1);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin : main
        logic [11:0] wpat;
        logic [5:0]  rpat;
        logic [4:0]  mpat;
        logic [8:0]  opat;
        int          k, rx0;
        wpat = 12'b1011_0010_1110;
        rpat = 6'b101101;
        mpat = 5'b10011;
        opat = 9'b110010111;

        rst = 1'b1; ss_n = 1'b1; sclk = 1'b0; mosi = 1'b0; spi_mode = 2'd0;
        read_mode = 1'b0; frame_period = 16'(PERIOD); frm_ready = 1'b1;
        tick(5);
        rst = 1'b0;
        tick(1);
        // R1
        chk(frm_valid == 1'b0, "R1 valid after reset", int'(frm_valid), 0);
        chk(ovf_err == 1'b0, "R1 ovf after reset", int'(ovf_err), 0);

        // R2 / R10: idle frames
        chk_interval = 1'b1;
        wait_frames(4);
        chk(last_ss == 1'b1, "R10 idle ss", int'(last_ss), 1);
        chk(last_cnt == 0, "R10 idle count", last_cnt, 0);

        // R5 / R6: write burst, mode 0
        ss_n = 1'b0; tick(6);
        for (int i = 11; i >= 0; i--) send_bit(wpat[i], 6, 1'b1);
        tick(8); ss_n = 1'b1;
        wait_drain();
        chk(exp_q.size() == 0, "R5 write burst drained", exp_q.size(), 0);

        // R4: clock edges with slave select high
        rx0 = bits_rx;
        for (int i = 0; i < 4; i++) send_bit(1'b1, 4, 1'b0);
        wait_frames(3);
        chk(bits_rx == rx0, "R4 ignored while ss high", bits_rx - rx0, 0);

        // R7: read mode
        read_mode = 1'b1;
        ss_n = 1'b0; tick(6);
        for (int i = 5; i >= 0; i--) send_bit(rpat[i], 3, 1'b1);
        tick(8); ss_n = 1'b1;
        wait_drain();
        chk(exp_q.size() == 0, "R7 read burst drained", exp_q.size(), 0);
        read_mode = 1'b0;

        // R8: short slave-select pulse
        ss_n = 1'b0;
        wait_frames(2);
        chk(last_ss == 1'b0, "R8 ss low reported", int'(last_ss), 0);
        tick(10);
        ss_n = 1'b1; tick(3); ss_n = 1'b0;
        k = frames;
        while (frames < k + 1) tick(1);
        chk(last_ss == 1'b1, "R8 pulse reported", int'(last_ss), 1);
        wait_frames(1);
        chk(last_ss == 1'b0, "R8 pulse cleared", int'(last_ss), 0);

        // R11: mode 1 samples on falling edge
        spi_mode = 2'd1;
        for (int i = 4; i >= 0; i--) send_bit(mpat[i], 5, 1'b1);
        tick(8);
        wait_drain();
        chk(exp_q.size() == 0, "R11 mode 1 drained", exp_q.size(), 0);
        ss_n = 1'b1; spi_mode = 2'd0;
        tick(4);

        // R9 / R3: overflow while stalled
        chk_interval = 1'b0;
        tick(1);
        frm_ready = 1'b0;
        ss_n = 1'b0; tick(6);
        for (int i = 8; i >= 0; i--) send_bit(opat[i], 4, i != 0);
        tick(8);
        chk(ovf_err == 1'b1, "R9 overflow flagged", int'(ovf_err), 1);
        chk(frm_valid == 1'b1, "R3 valid held", int'(frm_valid), 1);
        ss_n = 1'b1;
        frm_ready = 1'b1;
        wait_drain();
        wait_frames(2);
        chk(exp_q.size() == 0, "R9 first eight delivered", exp_q.size(), 0);
        chk(ovf_err == 1'b1, "R9 overflow sticky", int'(ovf_err), 1);

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            summary();
            $finish;
        end
    end

endmodule